// File: doc/BRIEF.md
# Locked I2C Register Target

This block is an I2C target for standard and fast mode rates. It holds eight configuration bytes behind an access lock. SCL and SDA come in as raw pins. They are oversampled on a system clock that runs at least ten times the SCL rate. The block answers by pulling SDA low through an open-drain enable. Its 7-bit bus address is chosen by a five-level strap code. Every register byte is visible on a flat output vector. A one-cycle pulse reports a software reset.

A write transfer sends an 8-bit offset and then data bytes, least significant first. A read transfer is two transactions: a write that carries only the offset, then a read that returns bytes from that offset. A shared byte pointer advances inside its four-byte group and wraps from the last byte of the group to the first. A group of four bytes therefore stays aligned.

The unlock register sits at offset 0x40 and is always open. Writing the key 0xAE there opens the bank at offsets 0x00 to 0x07 and the reset control at 0x41.

The protocol state machine has these states:
- IDLE waits for a START.
- ADDR collects the address byte.
- ADDR_ACK drives the address acknowledge.
- OFFS collects the offset byte.
- OFFS_ACK drives the offset acknowledge.
- WDATA collects a data byte.
- WDATA_ACK drives the data acknowledge.
- RDATA shifts out a read byte.
- RDATA_ACK samples the controller's acknowledge.
- IGNORE waits for STOP.

The transitions, all taken on a falling SCL edge except START and STOP, are:
- ADDR→ADDR_ACK when the address matches, or ADDR→IGNORE when it does not.
- ADDR_ACK→OFFS for a write, or ADDR_ACK→RDATA for a read.
- OFFS→OFFS_ACK→WDATA.
- WDATA→WDATA_ACK→WDATA.
- RDATA→RDATA_ACK.
- RDATA_ACK→RDATA on ACK, or RDATA_ACK→IGNORE on NACK.
- A START moves any state to ADDR, and a STOP moves any state to IDLE.

Top module: `locked_i2c_regs`

## Requirements
- R1: The 7-bit address follows the strap code: 0 (ground) and 1 (supply) select 0x12, 2 (pull-down) selects 0x16, 3 (pull-up) selects 0x1E, and 4 (open) selects 0x1A. Codes 5 to 7 behave as open.
- R2: An address byte that does not match is not acknowledged, and the rest of that transaction changes nothing.
- R3: After reset, the register bytes 0x00 to 0x07 hold 0x80, 0x80, 0x8D, 0x18, 0x80, 0x80, 0x8D, 0x38, and the lock is engaged. While locked, writes to the bank are acknowledged but ignored, and reads of it return 0x00.
- R4: Writing 0xAE to offset 0x40 releases the lock. Any other value leaves the lock engaged.
- R5: A write transaction carries the offset byte and then data bytes, least significant first. Every byte is acknowledged. The pointer steps within its four-byte group, wrapping from the last byte of the group to the first.
- R6: After an offset-only write, a read transaction returns bytes from that offset, least significant first, with the same pointer stepping. A NACK from the controller ends the data.
- R7: The low nibble of the bytes at offsets 0x01 and 0x05 always reads 0, whatever value is written.
- R8: While unlocked, writing a byte with bit 0 set to offset 0x41 gives one pulse of `soft_rst_o`, restores every register to its reset value and engages the lock again. Writing 0 there has no effect, and offset 0x41 always reads 0x00.
- R9: Offsets outside 0x00 to 0x07, 0x40 and 0x41 are acknowledged, writes to them are ignored, and reads of them return 0x00.
- R10: The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_code | input | 3 | Five-level address strap code (0 to 4) |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| regs_o | output | 64 | Register bytes, offset n at bits 8n+7:8n |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The software reset is decoded and carried out by the register bank in the same cycles in which the protocol machine launches the acknowledge for the byte that caused it. A reset must not cut that acknowledge short or desynchronize the transfer. The bench provokes this with one four-byte write at offset 0x40 that carries 0xAE, then 0x01, then two filler bytes. The first byte unlocks, the second resets and relocks, and the last two fall on unmapped offsets. The bench judges the result from three things:
- every byte was acknowledged;
- exactly one reset pulse was seen;
- the registers are back at reset values and the lock rejects a following write.

// File: rtl/locked_i2c_regs_pkg.sv
package locked_i2c_regs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_t;

    localparam logic [7:0] OFF_UNLOCK = 8'h40;
    localparam logic [7:0] OFF_SWRST  = 8'h41;
    localparam logic [7:0] UNLOCK_KEY = 8'hAE;

    function automatic logic [7:0] reg_init(input int idx);
        case (idx)
            0, 1, 4, 5: return 8'h80;
            2, 6:       return 8'h8D;
            3:          return 8'h18;
            7:          return 8'h38;
            default:    return 8'h00;
        endcase
    endfunction

    // squelch bytes keep their low nibble at zero
    function automatic logic [7:0] keep_mask(input int idx);
        return (idx == 1 || idx == 5) ? 8'hF0 : 8'hFF;
    endfunction

    function automatic logic [6:0] strap_addr(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: return 7'b0010010;
            3'd2:       return 7'b0010110;
            3'd3:       return 7'b0011110;
            default:    return 7'b0011010;
        endcase
    endfunction

endpackage

// File: rtl/locked_i2c_regs_sync.sv
module locked_i2c_regs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/locked_i2c_regs_bank.sv
module locked_i2c_regs_bank
    import locked_i2c_regs_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] regs_o,
    output logic              unlocked_o,
    output logic              soft_rst_o
);
    localparam int         IW   = $clog2(NREG);
    localparam logic [7:0] LAST = 8'(NREG - 1);

    logic [7:0] bank [NREG];
    logic       in_bank;

    assign in_bank = (addr <= LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) bank[i] <= reg_init(i);
            unlocked_o <= 1'b0;
            soft_rst_o <= 1'b0;
        end else begin
            soft_rst_o <= 1'b0;
            if (wr_en) begin
                if (addr == OFF_UNLOCK) begin
                    if (wdata == UNLOCK_KEY) unlocked_o <= 1'b1;
                end else if (unlocked_o && addr == OFF_SWRST) begin
                    if (wdata[0]) begin
                        for (int i = 0; i < NREG; i++) bank[i] <= reg_init(i);
                        unlocked_o <= 1'b0;
                        soft_rst_o <= 1'b1;
                    end
                end else if (unlocked_o && in_bank) begin
                    bank[addr[IW-1:0]] <= wdata & keep_mask(int'(addr[IW-1:0]));
                end
            end
        end
    end

    assign rd_data = (unlocked_o && in_bank) ? bank[addr[IW-1:0]] : 8'h00;

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g*8 +: 8] = bank[g];
    end
endmodule

// File: rtl/locked_i2c_regs.sv
module locked_i2c_regs
    import locked_i2c_regs_pkg::*;
#(
    parameter int REG_COUNT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             strap_code,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [REG_COUNT*8-1:0] regs_o,
    output logic                   soft_rst_o
);
    localparam int REG_BITS = REG_COUNT * 8;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] my_addr;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh, ptr, rd_data, wr_data, next_ptr;
    logic       rw_q, nack_q, wr_en, unlocked, byte_done;
    bus_state_t state_q, state_d;

    locked_i2c_regs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    locked_i2c_regs_bank #(.NREG(REG_COUNT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wdata(wr_data),
        .rd_data(rd_data), .regs_o(regs_o), .unlocked_o(unlocked),
        .soft_rst_o(soft_rst_o)
    );

    assign my_addr   = strap_addr(strap_code);
    assign byte_done = (bit_cnt == 4'd8);
    assign next_ptr  = {ptr[7:2], ptr[1:0] + 2'd1};

    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR:      if (byte_done) state_d = (rx_sh[7:1] == my_addr) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  state_d = rw_q ? ST_RDATA : ST_OFFS;
                ST_OFFS:      if (byte_done) state_d = ST_OFFS_ACK;
                ST_OFFS_ACK:  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: state_d = ST_WDATA;
                ST_RDATA:     if (byte_done) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: state_d = nack_q ? ST_IGNORE : ST_RDATA;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            wr_data <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            wr_en   <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det || start_det) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                if (scl_rise) begin
                    if (state_q inside {ST_ADDR, ST_OFFS, ST_WDATA, ST_RDATA}) begin
                        rx_sh   <= {rx_sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (state_q == ST_RDATA_ACK) nack_q <= sda_s;
                end
                if (scl_fall) begin
                    if (state_q == ST_ADDR && byte_done) rw_q <= rx_sh[0];
                    if (state_q == ST_OFFS && byte_done) ptr <= rx_sh;
                    if (state_q == ST_WDATA && byte_done) begin
                        wr_en   <= 1'b1;
                        wr_data <= rx_sh;
                    end
                    if (state_q == ST_WDATA_ACK) ptr <= next_ptr;

                    if (state_d inside {ST_ADDR_ACK, ST_OFFS_ACK, ST_WDATA_ACK}) begin
                        sda_oe  <= 1'b1;
                        bit_cnt <= '0;
                    end else if (state_d == ST_RDATA && state_q != ST_RDATA) begin
                        tx_sh   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        bit_cnt <= '0;
                    end else if (state_q == ST_RDATA && !byte_done) begin
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                        sda_oe <= ~tx_sh[6];
                    end else if (state_q == ST_RDATA) begin
                        sda_oe <= 1'b0;
                        ptr    <= next_ptr;
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/locked_i2c_regs_chk.sv
module locked_i2c_regs_chk #(
    parameter int REG_BITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                sda_oe,
    input logic                unlocked,
    input logic [REG_BITS-1:0] regs_o,
    input logic                soft_rst_o
);
    // R10
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R8
    swrst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R8
    swrst_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> !unlocked);

    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(regs_o));

    // R7
    squelch_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[11:8] == 4'h0 && regs_o[43:40] == 4'h0);
endmodule

bind locked_i2c_regs locked_i2c_regs_chk #(.REG_BITS(REG_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .unlocked(unlocked), .regs_o(regs_o), .soft_rst_o(soft_rst_o)
);

// File: tb/locked_i2c_regs_test.sv
module locked_i2c_regs_test;
    localparam int          Q   = 10;
    localparam logic [63:0] RST = 64'h388D8080_188D8080;
    localparam logic [6:0]  DEV = 7'h12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap = 3'd0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe, swrst;
    logic [63:0] regs;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int swrst_cnt = 0;

    always #10 clk = ~clk;

    locked_i2c_regs uut (
        .clk(clk), .rst_n(rst_n), .strap_code(strap), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .regs_o(regs), .soft_rst_o(swrst)
    );

    always @(negedge clk) if (swrst) swrst_cnt++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic last, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl_m = 1'b1;
            tick(Q); b = {b[6:0], sda_bus};
            tick(Q); scl_m = 1'b0;
            tick(Q);
        end
        sda_m = last; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic reg_write(input logic [6:0] dev, input logic [7:0] off, input int n,
                             input logic [31:0] data, output logic all_ack);
        logic a;
        bus_start();
        put_byte({dev, 1'b0}, a); all_ack = a;
        put_byte(off, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            put_byte(data[i*8 +: 8], a); all_ack &= a;
        end
        bus_stop();
        tick(Q);
    endtask

    task automatic reg_read(input logic [6:0] dev, input logic [7:0] off, input int n,
                            output logic [31:0] data);
        logic       a;
        logic [7:0] b;
        data = '0;
        bus_start();
        put_byte({dev, 1'b0}, a);
        put_byte(off, a);
        bus_stop();
        bus_start();
        put_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) begin
            get_byte(i == n - 1, b);
            data[i*8 +: 8] = b;
        end
        bus_stop();
        tick(Q);
    endtask

    task automatic t_reset_state();
        check("R3 reset image", regs, RST);
        check("R10 sda released after reset", {63'b0, sda_oe}, 64'd0);
        check("R8 no pulse after reset", {63'b0, swrst}, 64'd0);
    endtask

    task automatic t_strap_addr();
        logic [6:0] exp_addr [6] = '{7'h12, 7'h12, 7'h16, 7'h1E, 7'h1A, 7'h1A};
        logic       ack;
        for (int c = 0; c < 6; c++) begin
            strap = 3'(c);
            tick(4);
            reg_write(exp_addr[c], 8'h08, 0, 32'h0, ack);
            check($sformatf("R1 strap %0d acked", c), {63'b0, ack}, 64'd1);
        end
        strap = 3'd0;
        tick(4);
        reg_write(7'h13, 8'h40, 1, 32'hAE, ack);
        check("R2 wrong address nacked", {63'b0, ack}, 64'd0);
        reg_write(DEV, 8'h00, 1, 32'h5A, ack);
        check("R2 no unlock from foreign address", regs, RST);
    endtask

    task automatic t_locked();
        logic        ack;
        logic [31:0] d;
        reg_write(DEV, 8'h00, 4, 32'h01020304, ack);
        check("R3 locked write acked", {63'b0, ack}, 64'd1);
        check("R3 locked write ignored", regs, RST);
        reg_read(DEV, 8'h00, 4, d);
        check("R3 locked read zero", {32'b0, d}, 64'd0);
    endtask

    task automatic t_bad_key();
        logic ack;
        reg_write(DEV, 8'h40, 1, 32'h55, ack);
        reg_write(DEV, 8'h03, 1, 32'h07, ack);
        check("R4 wrong key keeps lock", regs, RST);
    endtask

    task automatic t_unlock_write();
        logic ack;
        reg_write(DEV, 8'h40, 1, 32'hAE, ack);
        reg_write(DEV, 8'h00, 4, 32'h44332211, ack);
        check("R5 four byte write acked", {63'b0, ack}, 64'd1);
        check("R5 R7 four byte write lsb first", {32'b0, regs[31:0]}, 64'h44332011);
    endtask

    task automatic t_read();
        logic [31:0] d;
        reg_read(DEV, 8'h00, 4, d);
        check("R6 four byte read", {32'b0, d}, 64'h44332011);
        reg_read(DEV, 8'h06, 1, d);
        check("R6 single byte read", {32'b0, d}, 64'h8D);
        reg_read(DEV, 8'h03, 1, d);
        check("R6 single byte read top", {32'b0, d}, 64'h44);
    endtask

    task automatic t_wrap();
        logic ack;
        reg_write(DEV, 8'h06, 4, 32'hA4A3A2A1, ack);
        check("R5 R7 pointer wraps in group", {32'b0, regs[63:32]}, 64'hA2A1A0A3);
    endtask

    task automatic t_unmapped();
        logic        ack;
        logic [31:0] d;
        logic [63:0] snap;
        snap = regs;
        reg_write(DEV, 8'h08, 4, 32'hFFFFFFFF, ack);
        check("R9 unmapped write acked", {63'b0, ack}, 64'd1);
        check("R9 unmapped write ignored", regs, snap);
        reg_read(DEV, 8'h08, 4, d);
        check("R9 unmapped read zero", {32'b0, d}, 64'd0);
    endtask

    task automatic t_soft_reset();
        logic        ack;
        logic [31:0] d;
        logic [63:0] snap;
        snap = regs;
        swrst_cnt = 0;
        reg_write(DEV, 8'h41, 1, 32'h00, ack);
        check("R8 zero write no reset", regs, snap);
        check("R8 zero write no pulse", 64'(swrst_cnt), 64'd0);
        reg_read(DEV, 8'h41, 1, d);
        check("R8 reset control reads zero", {32'b0, d}, 64'd0);
        reg_write(DEV, 8'h40, 4, 32'h000001AE, ack);
        check("R8 reset byte and neighbours acked", {63'b0, ack}, 64'd1);
        check("R8 one reset pulse", 64'(swrst_cnt), 64'd1);
        check("R8 registers restored", regs, RST);
        reg_write(DEV, 8'h00, 1, 32'h5A, ack);
        check("R8 lock engaged again", regs, RST);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset_state();
        t_strap_addr();
        t_locked();
        t_bad_key();
        t_unlock_write();
        t_read();
        t_wrap();
        t_unmapped();
        t_soft_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule